// File: doc/BRIEF.md
# Two-Stage PLL Lock Sequencing Timer

This block orders the power-up of a clock domain that depends on a PLL. It runs from a fixed 25 MHz reference clock and has one input besides the clock: an asynchronous active-low reset. While that reset is asserted, the block holds its standby output high and its lock indication low. After the reset is released, a first one-shot interval runs and then drops standby. A second, much longer one-shot interval then starts, and at its end the lock indication rises. Both outputs keep their final levels until the next reset.

The reset input feeds an internal two-flop synchronizer. That synchronizer clears all state at once when reset is asserted and lets it go on a clock edge. A three-state controller drives both outputs. Its states are: HOLD, in which standby is high and the first interval is timed; WAIT, in which standby is low and the second interval is timed; and DONE, in which lock is high. The controller has two transitions. HOLD to WAIT fires when the first interval timer expires. WAIT to DONE fires when the second interval timer expires. Any assertion of reset returns the controller to HOLD from every state. The two interval lengths are parameters, `STBY_CYCLES` (default 63, which is 2.52 µs at 25 MHz) and `LOCK_CYCLES` (default 25000, which is 1 ms). Each timer stops at its terminal count and does not wrap.

Top module: `pll_lock_sequencer`

## Requirements
- R1: While `rst_n` is low, `standby_o` is 1 and `lock_o` is 0. This takes effect as soon as `rst_n` falls, without waiting for a clock edge.
- R2: Number the rising edges of `clk` from 0, where edge 0 is the first edge at which `rst_n` is high after release. `standby_o` stays 1 through edge `STBY_CYCLES`+1 and becomes 0 right after edge `STBY_CYCLES`+2. It is therefore high for at least `STBY_CYCLES` cycles after the synchronized release.
- R3: Once `standby_o` is 0, it stays 0 until `rst_n` falls again.
- R4: `lock_o` stays 0 through edge `STBY_CYCLES`+`LOCK_CYCLES`+2 and becomes 1 right after edge `STBY_CYCLES`+`LOCK_CYCLES`+3. This puts at least `LOCK_CYCLES` cycles between the fall of standby and the rise of lock.
- R5: Once `lock_o` is 1, it stays 1 until `rst_n` falls again.
- R6: `lock_o` is never 1 while `standby_o` is 1.
- R7: If `rst_n` is asserted during the first interval or during the second interval, the block returns to its reset state. After the next release, the full sequence runs again with the same timing as R2 and R4.
- R8: If `rst_n` is asserted after the sequence has completed, `lock_o` drops and `standby_o` rises. After the next release, the sequence repeats with the timing of R2 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; synchronized inside the block for release |
| standby_o | output | 1 | High from reset until the first interval ends, then low |
| lock_o | output | 1 | Low until the second interval ends, then high |

## Verification
The bench drives four reset patterns through the block.

1. An uninterrupted release. This pins both transitions to the exact edge given in R2 and R4, and shows the levels stay put over the cycles that follow.
2. A reset dropped partway through HOLD.
3. A reset dropped partway through WAIT.
4. A reset applied after DONE has been reached.

Each of the last three patterns is followed by a complete sequence. These separate a controller that truly restarts from one that resumes. They also catch a timer that keeps stale counts from the aborted run. Every reset assertion lands between clock edges, which shows whether the outputs react asynchronously or wait for the next edge.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'b00,
        SEQ_WAIT = 2'b01,
        SEQ_DONE = 2'b10
    } seq_state_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lockseq_rst_sync.sv
module lockseq_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= 1'b0;
                else         chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lockseq_timer.sv
module lockseq_timer #(
    parameter int unsigned LIMIT = 63,
    localparam int unsigned W = lockseq_pkg::cnt_width(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam logic [W-1:0] TERM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != TERM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == TERM);

endmodule

// File: rtl/lockseq_fsm.sv
module lockseq_fsm
    import lockseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stby_expired,
    input  logic lock_expired,
    output logic hold_run,
    output logic wait_run,
    output logic standby_o,
    output logic lock_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HOLD: if (stby_expired) state_d = SEQ_WAIT;
            SEQ_WAIT: if (lock_expired) state_d = SEQ_DONE;
            SEQ_DONE: state_d = SEQ_DONE;
            default:  state_d = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        hold_run  = 1'b0;
        wait_run  = 1'b0;
        standby_o = 1'b1;
        lock_o    = 1'b0;
        unique case (state_q)
            SEQ_HOLD: hold_run = 1'b1;
            SEQ_WAIT: begin
                wait_run  = 1'b1;
                standby_o = 1'b0;
            end
            SEQ_DONE: begin
                standby_o = 1'b0;
                lock_o    = 1'b1;
            end
            default: begin
                standby_o = 1'b1;
                lock_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pll_lock_sequencer.sv
module pll_lock_sequencer #(
    parameter int unsigned STBY_CYCLES = 63,
    parameter int unsigned LOCK_CYCLES = 25000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic standby_o,
    output logic lock_o
);

    logic srst_n;
    logic hold_run;
    logic wait_run;
    logic stby_expired;
    logic lock_expired;

    lockseq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (rst_n),
        .srst_n (srst_n)
    );

    lockseq_timer #(.LIMIT(STBY_CYCLES)) u_stby_timer (
        .clk     (clk),
        .rst_n   (srst_n),
        .run     (hold_run),
        .expired (stby_expired)
    );

    lockseq_timer #(.LIMIT(LOCK_CYCLES)) u_lock_timer (
        .clk     (clk),
        .rst_n   (srst_n),
        .run     (wait_run),
        .expired (lock_expired)
    );

    lockseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (srst_n),
        .stby_expired (stby_expired),
        .lock_expired (lock_expired),
        .hold_run     (hold_run),
        .wait_run     (wait_run),
        .standby_o    (standby_o),
        .lock_o       (lock_o)
    );

endmodule

// File: rtl/lockseq_chk.sv
module lockseq_chk #(
    parameter int unsigned N1 = 63,
    parameter int unsigned N2 = 25000
) (
    input logic clk,
    input logic rst_n,
    input logic standby_o,
    input logic lock_o
);

    logic [31:0] rel_cnt;
    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rel_cnt <= '0;
        else if (rel_cnt != '1)      rel_cnt <= rel_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  low_cnt <= '0;
        else if (standby_o)          low_cnt <= '0;
        else if (low_cnt != '1)      low_cnt <= low_cnt + 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LEVELS: assert (standby_o && !lock_o); // R1
        end
    end

    AST_STBY_MIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby_o) |-> (rel_cnt >= 32'(N1))); // R2

    AST_STBY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_o |=> !standby_o); // R3

    AST_LOCK_MIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> (low_cnt >= 32'(N2))); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o); // R5

    AST_LOCK_AFTER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !standby_o); // R6

endmodule

bind pll_lock_sequencer lockseq_chk #(.N1(STBY_CYCLES), .N2(LOCK_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_o (standby_o),
    .lock_o    (lock_o)
);

// File: tb/pll_lock_sequencer_tb.sv
`timescale 1ns/1ps
module pll_lock_sequencer_tb;

    localparam int unsigned N1 = 63;
    localparam int unsigned N2 = 25000;
    localparam int unsigned STBY_EDGE = N1 + 2;
    localparam int unsigned LOCK_EDGE = N1 + N2 + 3;
    localparam int unsigned WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_o;
    logic lock_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pll_lock_sequencer #(.STBY_CYCLES(N1), .LOCK_CYCLES(N2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_o (standby_o),
        .lock_o    (lock_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // R1: assert reset between edges, outputs react before any clock edge
    task automatic apply_reset(input string tag);
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        check(tag, "standby during reset", standby_o, 1'b1);
        check(tag, "lock during reset", lock_o, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "standby held in reset", standby_o, 1'b1);
        check("R1", "lock held in reset", lock_o, 1'b0);
    endtask

    // Full release: R2, R3, R4, R5, R6 checked edge by edge
    task automatic run_full(input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i <= int'(LOCK_EDGE) + 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < int'(STBY_EDGE)) check("R2", {tag, " standby before fall"}, standby_o, 1'b1);
            else                     check("R3", {tag, " standby after fall"}, standby_o, 1'b0);
            if (i < int'(LOCK_EDGE)) check("R4", {tag, " lock before rise"}, lock_o, 1'b0);
            else                     check("R5", {tag, " lock after rise"}, lock_o, 1'b1);
            check("R6", {tag, " lock with standby"}, lock_o && standby_o, 1'b0);
        end
    endtask

    // R7: abort in first interval
    task automatic abort_hold();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R7", "standby mid first interval", standby_o, 1'b1);
        apply_reset("R7");
        run_full("R7 after hold abort");
    endtask

    // R7: abort in second interval
    task automatic abort_wait();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (STBY_EDGE + 100) @(posedge clk);
        @(negedge clk);
        check("R7", "standby mid second interval", standby_o, 1'b0);
        check("R7", "lock mid second interval", lock_o, 1'b0);
        apply_reset("R7");
        run_full("R7 after wait abort");
    endtask

    // R8: reset after completion
    task automatic reset_after_done();
        check("R8", "lock before re-reset", lock_o, 1'b1);
        apply_reset("R8");
        run_full("R8 rerun");
    endtask

    initial begin
        #1;
        check("R1", "standby at start", standby_o, 1'b1);
        check("R1", "lock at start", lock_o, 1'b0);
        repeat (4) @(posedge clk);
        run_full("first");
        reset_after_done();
        apply_reset("R1");
        abort_hold();
        apply_reset("R1");
        abort_wait();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule